// File: doc/BRIEF.md
# Signed Fractional Multiply/Divide Unit

This block is a sequential arithmetic engine for 32-bit two's-complement words. A request carries two operands, an accumulator value and a memory value, and an operation code. The unit either multiplies them and returns one half of the signed product, or treats the pair as fractions and divides the accumulator by the memory word, returning a rounded fractional quotient. Both paths strip the signs first and work on magnitudes. Multiply uses one shift-and-add step per cycle. Divide uses one restoring shift-and-subtract step per cycle. The sign is reapplied at the end.

The request side is a valid/ready port. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle, so a requester that sees it low must hold its request until it returns high. A request offered while the unit is busy has no effect. The response side has no back-pressure. `out_valid` is a one-cycle strobe, and `out_result` and `out_ovf` stay unchanged until the next response, so the consumer may read them later. A divide whose quotient cannot be represented reports overflow after one cycle and returns the dividend unchanged.

Top module: `frac_muldiv`

## Requirements
- R1: A request is accepted only on a rising edge with `in_valid` and `in_ready` both high. `in_ready` is low from the cycle after acceptance until the cycle in which `out_valid` is high. A request presented while `in_ready` is low is ignored and does not alter the result of the operation in progress.
- R2: `out_valid` is high for exactly one cycle per accepted request. `out_result` and `out_ovf` change only in a cycle where `out_valid` is high.
- R3: `in_op` encoding: 2'b00 selects low product, 2'b01 selects high product, and 2'b10 and 2'b11 both select divide.
- R4: Low product: `out_result` is bits [31:0] of the 64-bit signed product of `in_acc` and `in_mem`.
- R5: High product: `out_result` is bits [63:32] of the 64-bit signed product, shifted left one place with a zero entering bit 0 and the top bit dropped.
- R6: If either multiplier operand is zero, both product selections return zero.
- R7: Divide with |acc| >= |mem|, a zero divisor included, sets `out_ovf` to 1 and returns `in_acc` unchanged.
- R8: Otherwise divide returns q = floor(|acc| * 2^31 / |mem|), then (q + 1) with bit 0 cleared, negated when the operand sign bits differ. `out_ovf` is 0 and bit 0 of the result is 0.
- R9: Both multiply selections always return `out_ovf` = 0.
- R10: `out_valid` rises after 33 rising edges following the accept edge for multiply, 32 for a divide that does not overflow, and 1 for an overflowing divide.
- R11: During and after reset, with no request yet, `in_ready` is 1, `out_valid` is 0, `out_result` is 0 and `out_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to take a request |
| in_op | input | 2 | Operation code (R3) |
| in_acc | input | 32 | Accumulator operand, multiplicand or dividend |
| in_mem | input | 32 | Memory operand, multiplier or divisor |
| out_valid | output | 1 | One-cycle response strobe |
| out_result | output | 32 | Result word, held until the next response |
| out_ovf | output | 1 | Divide overflow, held with the result |

## Verification
The bench builds the unit with its default word width of 32 so that its reference arithmetic, done on 64-bit integers, covers every product and quotient exactly. At this width the full-scale negative operand -2^31 is reachable. Its magnitude uses the top bit of the unsigned magnitude path, so the bench exercises it as a multiplicand, as a multiplier and as a divisor. The same width gives iteration counts of 32 and 31, so the latency checks fix the exact step counts. Zero divisors, equal magnitudes and the smallest nonzero quotients reach the overflow boundary and the rounding step.

// File: rtl/frac_md_pkg.sv
package frac_md_pkg;
  typedef enum logic [1:0] {
    OP_MUL_LO  = 2'b00,
    OP_MUL_HI  = 2'b01,
    OP_DIV     = 2'b10,
    OP_DIV_ALT = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10
  } md_state_e;
endpackage

// File: rtl/frac_md_mag.sv
module frac_md_mag #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);
  localparam logic [W-1:0] ONE = W'(1);

  // Unsigned magnitude; -2^(W-1) maps to 2^(W-1), which fits W bits.
  always_comb begin
    neg_o = val_i[W-1];
    mag_o = neg_o ? (~val_i + ONE) : val_i;
  end
endmodule

// File: rtl/frac_md_mul.sv
module frac_md_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0] hi_q, lo_q, mc_q;
  logic [W:0]   sum;

  always_comb begin
    sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mc_q} : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      mc_q <= '0;
    end else if (load) begin
      hi_q <= '0;
      lo_q <= mplier_i;
      mc_q <= mcand_i;
    end else if (step) begin
      {hi_q, lo_q} <= {sum, lo_q[W-1:1]};
    end
  end

  assign prod_o = {hi_q, lo_q};

  // A magnitude product never exceeds 2^(2W-2), so the top bit stays clear.
  assert_mul_top_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !hi_q[W-1]);
endmodule

// File: rtl/frac_md_div.sv
module frac_md_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvr_i,
  output logic [W-1:0] quo_o
);
  logic [W:0]   rem_q;
  logic [W-1:0] dvr_q;
  logic [W-1:0] quo_q;
  logic [W:0]   shifted;
  logic [W:0]   trial;
  logic         fits;

  always_comb begin
    shifted = rem_q << 1;
    fits    = shifted >= {1'b0, dvr_q};
    trial   = shifted - {1'b0, dvr_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvr_q <= '0;
      quo_q <= '0;
    end else if (load) begin
      rem_q <= {1'b0, dvd_i};
      dvr_q <= dvr_i;
      quo_q <= '0;
    end else if (step) begin
      rem_q <= fits ? trial : shifted;
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  assign quo_o = quo_q;

  // Restoring invariant: the partial remainder stays below the divisor.
  assert_rem_below_divisor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (rem_q < {1'b0, dvr_q}));
endmodule

// File: rtl/frac_muldiv.sv
module frac_muldiv
  import frac_md_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_acc,
  input  logic [W-1:0] in_mem,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         out_ovf
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] MUL_LAST = CW'(W - 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(W - 2);
  localparam logic [W-1:0]   ONE  = W'(1);
  localparam logic [2*W-1:0] ONE2 = (2*W)'(1);

  md_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic op_div_q, op_hi_q, neg_q, ovf_pend_q;
  logic [W-1:0] acc_q;
  logic [W-1:0] res_q;
  logic ovf_q, vld_q;

  // Operand magnitudes, one converter per operand
  logic [W-1:0] opnd [2];
  logic [W-1:0] mag  [2];
  logic         sgn  [2];

  assign opnd[0] = in_acc;
  assign opnd[1] = in_mem;

  for (genvar g = 0; g < 2; g++) begin : g_mag
    frac_md_mag #(.W(W)) u_mag (
      .val_i (opnd[g]),
      .mag_o (mag[g]),
      .neg_o (sgn[g])
    );
  end

  logic accept, div_in, div_ovf_in, last_step;
  logic mul_step, div_step;

  always_comb begin
    accept     = in_valid && (state_q == ST_IDLE);
    div_in     = in_op inside {OP_DIV, OP_DIV_ALT};
    div_ovf_in = div_in && (mag[0] >= mag[1]);
    mul_step   = (state_q == ST_RUN) && !op_div_q;
    div_step   = (state_q == ST_RUN) && op_div_q;
    last_step  = cnt_q == (op_div_q ? DIV_LAST : MUL_LAST);
  end

  logic [2*W-1:0] prod;
  logic [W-1:0]   quo;

  frac_md_mul #(.W(W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (mul_step),
    .mcand_i  (mag[0]),
    .mplier_i (mag[1]),
    .prod_o   (prod)
  );

  frac_md_div #(.W(W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .step  (div_step),
    .dvd_i (mag[0]),
    .dvr_i (mag[1]),
    .quo_o (quo)
  );

  // Sign restore and result selection
  logic [2*W-1:0] prod_s;
  logic [W-1:0]   hi_val, q_rnd, q_s, fin;

  always_comb begin
    prod_s = neg_q ? (~prod + ONE2) : prod;
    hi_val = prod_s[2*W-1:W] << 1;
    q_rnd  = (quo + ONE) & ~ONE;
    q_s    = neg_q ? (~q_rnd + ONE) : q_rnd;
    if (ovf_pend_q)    fin = acc_q;
    else if (op_div_q) fin = q_s;
    else if (op_hi_q)  fin = hi_val;
    else               fin = prod_s[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      op_div_q   <= 1'b0;
      op_hi_q    <= 1'b0;
      neg_q      <= 1'b0;
      ovf_pend_q <= 1'b0;
      acc_q      <= '0;
      res_q      <= '0;
      ovf_q      <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_div_q   <= div_in;
            op_hi_q    <= (in_op == OP_MUL_HI);
            neg_q      <= sgn[0] ^ sgn[1];
            acc_q      <= in_acc;
            ovf_pend_q <= div_ovf_in;
            cnt_q      <= '0;
            state_q    <= div_ovf_in ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_step) state_q <= ST_DONE;
        end
        ST_DONE: begin
          res_q   <= fin;
          ovf_q   <= ovf_pend_q;
          vld_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready   = (state_q == ST_IDLE);
  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_ovf    = ovf_q;

  assert_ready_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_ready_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(out_result) || !$stable(out_ovf)) |-> out_valid);
  assert_mul_no_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !op_div_q) |-> !out_ovf);
  assert_quotient_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_div_q && !out_ovf) |-> !out_result[0]);
endmodule

// File: tb/frac_muldiv_bench.sv
module frac_muldiv_bench;
  localparam int W  = 32;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_op = 2'b00;
  logic [W-1:0] in_acc = '0;
  logic [W-1:0] in_mem = '0;
  logic out_valid;
  logic [W-1:0] out_result;
  logic out_ovf;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  frac_muldiv #(.W(W)) u_frac_muldiv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_acc(in_acc), .in_mem(in_mem),
    .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf)
  );

  // Stimulus table: op, accumulator, memory
  localparam logic [1:0] V_OP [NV] = '{
    2'b00, 2'b00, 2'b01, 2'b01, 2'b01, 2'b00, 2'b01, 2'b10,
    2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b11, 2'b00 };
  localparam logic [31:0] V_A [NV] = '{
    32'h0000_0003, 32'hFFFF_FFF9, 32'h4000_0000, 32'h8000_0000,
    32'hC000_0000, 32'h0000_0000, 32'h1234_5678, 32'h2000_0000,
    32'hF000_0000, 32'h0000_0001, 32'h4000_0000, 32'h1234_5678,
    32'h7FFF_FFFE, 32'h0000_0003, 32'h7FFF_FFFF };
  localparam logic [31:0] V_B [NV] = '{
    32'h0000_0005, 32'h0000_0009, 32'h4000_0000, 32'h8000_0000,
    32'h6000_0000, 32'h8000_0000, 32'h0000_0000, 32'h4000_0000,
    32'h3000_0000, 32'h7FFF_FFFF, 32'h4000_0000, 32'h0000_0000,
    32'h8000_0000, 32'hFFFF_FFF9, 32'h7FFF_FFFF };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model built from R4, R5, R7 and R8
  task automatic model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] res, output logic ovf, output int lat);
    logic [63:0] p, ma, mb, q;
    p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
    ovf = 1'b0;
    if (op[1] == 1'b0) begin
      res = (op[0] == 1'b0) ? p[31:0] : {p[62:32], 1'b0};
      lat = W + 1;
    end else begin
      ma = {32'b0, a[31] ? (~a + 32'd1) : a};
      mb = {32'b0, b[31] ? (~b + 32'd1) : b};
      if (ma >= mb) begin
        ovf = 1'b1;
        res = a;
        lat = 1;
      end else begin
        q = (ma << 31) / mb;
        q = (q + 64'd1) & ~64'd1;
        if (a[31] ^ b[31]) q = ~q + 64'd1;
        res = q[31:0];
        lat = W;
      end
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_acc = a; in_mem = b;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid && lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] exp_res, held;
    logic exp_ovf;
    int exp_lat, lat;
    string tag;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset values
    chk("R11 ready", {31'b0, in_ready}, 32'd1);
    chk("R11 valid", {31'b0, out_valid}, 32'd0);
    chk("R11 result", out_result, 32'd0);
    chk("R11 ovf", {31'b0, out_ovf}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after release", {31'b0, in_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      model(V_OP[i], V_A[i], V_B[i], exp_res, exp_ovf, exp_lat);
      if (V_OP[i] == 2'b11) tag = "R3";
      else if (!V_OP[i][1] && (V_A[i] == 0 || V_B[i] == 0)) tag = "R6";
      else if (V_OP[i] == 2'b00) tag = "R4";
      else if (V_OP[i] == 2'b01) tag = "R5";
      else if (exp_ovf) tag = "R7";
      else tag = "R8";
      run_op(V_OP[i], V_A[i], V_B[i], lat);
      chk($sformatf("%s result vec %0d", tag, i), out_result, exp_res);
      chk($sformatf("%s ovf vec %0d", V_OP[i][1] ? tag : "R9", i),
          {31'b0, out_ovf}, {31'b0, exp_ovf});
      chk($sformatf("R10 latency vec %0d", i), lat, exp_lat);
    end

    // R1: requests while busy are ignored
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b00; in_acc = 32'd6; in_mem = 32'd7;
    @(posedge clk);
    @(negedge clk);
    in_op = 2'b10; in_acc = 32'd1; in_mem = 32'd3;
    chk("R1 ready low while busy", {31'b0, in_ready}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R1 still busy", {31'b0, in_ready}, 32'd0);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk("R1 first request result", out_result, 32'd42);
    chk("R1 ready with done", {31'b0, in_ready}, 32'd1);

    // R2: one-cycle strobe, result held afterwards
    held = out_result;
    @(negedge clk);
    chk("R2 strobe one cycle", {31'b0, out_valid}, 32'd0);
    repeat (5) @(negedge clk);
    chk("R2 result held", out_result, held);
    chk("R2 ovf held", {31'b0, out_ovf}, 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule